// File: doc/BRIEF.md
# Dataflow Graph Dependency Tracker

This block takes a stream of decoded instructions belonging to one trace and builds the dataflow graph of that trace on the fly. Every accepted elementary operation gets the next free slot in a graph table. A producer table, indexed by architectural register, remembers which slot last wrote each register. Each source operand is then labelled as an external input, a constant, or a value produced by an earlier graph node. A per-slot output flag is set when a slot is filled and cleared as soon as a later operation consumes its result. The flags left set at the end of the trace are the live results of the graph.

Loads are cut points. A load keeps its output flag, and any consumer of its result sees a fresh external input instead of a graph edge. Register-to-address dependencies of the load itself are still recorded. A scaled-add instruction is broken into a shift node followed by an add node, and the two nodes take consecutive slots over two cycles. Each accepted node is reported one cycle later on a record port. A query port reads back the stored operation and output flag of any slot.

Top module: `dfg_tracker`

## Requirements
- R1: After reset or after a cycle with `trace_start` high, the table is empty: `qry_hit` is 0 for every slot and every register reads as an external input. An instruction presented together with `trace_start` is placed in slot 0 and sees only external inputs.
- R2: Accepted nodes take slots 0, 1, 2, ... in order. The record (`ent_valid` with `ent_idx` and the fields) appears in the cycle after the accepting clock edge.
- R3: A newly filled slot reads back with its output flag set (`qry_out`=1) and with the operation code it was written with (`qry_op`).
- R4: A slot's output flag is cleared when a later node uses it as a node operand. A slot whose result nobody consumes keeps its flag.
- R5: Operand kinds are encoded as 0 external (value = register number), 1 constant (value = `in_imm`) and 2 node (value = producing slot). Operand A is never a constant. A source naming the instruction's own destination sees the producer from before that instruction.
- R6: When a register is written again, later readers refer to the newest producing slot.
- R7: A load (op 6) writes the producer table as a cut. Readers of its destination get kind 0 with the register number, and the load's flag stays set. The load's own address operand is classified normally.
- R8: A scaled add (op 7) becomes two nodes. The first is a shift (op 5) with A = source A and B = constant `in_imm`. In the next cycle comes an add (op 0) with A = node of the shift slot and B = source B. `in_ready` is 0 for exactly that one cycle, and the shift's flag ends cleared.
- R9: An instruction whose nodes do not all fit in the remaining slots is dropped: no record, no slot used, producer table unchanged.
- R10: An instruction with `in_has_dst`=0 fills a slot but leaves the producer table unchanged.
- R11: When both sources name the same produced register, both operands report kind 2 with the same slot.
- Op codes: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift left, 6 load, 7 scaled add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_start | input | 1 | Begin a new trace (clears the tables) |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Low during the second cycle of a scaled add |
| in_op | input | 3 | Operation code |
| in_dst | input | RW | Destination register |
| in_has_dst | input | 1 | Instruction writes a register |
| in_src_a | input | RW | Source register A |
| in_src_b | input | RW | Source register B |
| in_b_imm | input | 1 | Operand B is the constant `in_imm` |
| in_imm | input | IMMW | Constant, or shift amount of a scaled add |
| ent_valid | output | 1 | A node record is present |
| ent_idx | output | IW | Slot of the node |
| ent_op | output | 3 | Elementary operation of the node |
| ent_kind_a | output | 2 | Kind of operand A |
| ent_val_a | output | VW | Register, constant or slot of operand A |
| ent_kind_b | output | 2 | Kind of operand B |
| ent_val_b | output | VW | Register, constant or slot of operand B |
| qry_idx | input | IW | Slot to read back |
| qry_hit | output | 1 | Slot is filled in the current trace |
| qry_out | output | 1 | Output flag of the slot |
| qry_op | output | 3 | Stored operation of the slot |

## Verification
The interesting collisions are a trace start in the same cycle as an insertion, and a node that reads and writes the same register in one cycle. In the first case the clear must lose to the new slot-0 write. In the second the lookup must see the old producer while the table takes the new one. The bench drives both directly: an instruction with `trace_start` high, and `r3 = r3 - 1`. It also raises `trace_start` at random alongside random instructions on a small register set. Records and read-back flags are compared with a bench model that applies the clear first, then classifies, then updates.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
    OP_XOR = 3'd4, OP_SHL = 3'd5, OP_LOAD = 3'd6, OP_SCADD = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    K_EXT = 2'd0, K_CONST = 2'd1, K_NODE = 2'd2
  } kind_e;
endpackage

// File: rtl/dfg_prod_table.sv
module dfg_prod_table #(
  parameter int NREG = 32,
  parameter int RW   = 5,
  parameter int IW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_reg,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_cut,
  input  logic [RW-1:0] ra,
  input  logic [RW-1:0] rb,
  output logic          a_live,
  output logic [IW-1:0] a_idx,
  output logic          b_live,
  output logic [IW-1:0] b_idx
);
  logic [NREG-1:0] vld;
  logic [NREG-1:0] cut;
  logic [IW-1:0]   pidx [NREG];

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      vld <= '0;
      cut <= '0;
    end
    if (!rst && wr_en) begin
      vld[wr_reg] <= 1'b1;
      cut[wr_reg] <= wr_cut;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) pidx[wr_reg] <= wr_idx;
  end

  assign a_live = vld[ra] && !cut[ra];
  assign a_idx  = pidx[ra];
  assign b_live = vld[rb] && !cut[rb];
  assign b_idx  = pidx[rb];
endmodule

// File: rtl/dfg_flag_array.sv
module dfg_flag_array #(
  parameter int DEPTH = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          c0_en,
  input  logic [IW-1:0] c0_idx,
  input  logic          c1_en,
  input  logic [IW-1:0] c1_idx,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_flag
);
  logic [DEPTH-1:0] flg, flg_n;

  always_comb begin
    flg_n = clr_all ? '0 : flg;
    if (c0_en) flg_n[c0_idx] = 1'b0;
    if (c1_en) flg_n[c1_idx] = 1'b0;
    if (set_en) flg_n[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg     <= '0;
      rd_flag <= 1'b0;
    end else begin
      flg     <= flg_n;
      rd_flag <= flg[rd_idx];
    end
  end
endmodule

// File: rtl/dfg_entry_ram.sv
module dfg_entry_ram #(
  parameter int DEPTH = 64,
  parameter int IW    = 6,
  parameter int DW    = 3
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/dfg_tracker.sv
module dfg_tracker
  import dfg_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int DEPTH = 64,
  parameter int IMMW  = 16,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(DEPTH),
  localparam int VW0  = (IMMW > RW) ? IMMW : RW,
  localparam int VW   = (VW0 > IW) ? VW0 : IW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trace_start,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [RW-1:0]   in_dst,
  input  logic            in_has_dst,
  input  logic [RW-1:0]   in_src_a,
  input  logic [RW-1:0]   in_src_b,
  input  logic            in_b_imm,
  input  logic [IMMW-1:0] in_imm,
  output logic            ent_valid,
  output logic [IW-1:0]   ent_idx,
  output logic [2:0]      ent_op,
  output logic [1:0]      ent_kind_a,
  output logic [VW-1:0]   ent_val_a,
  output logic [1:0]      ent_kind_b,
  output logic [VW-1:0]   ent_val_b,
  input  logic [IW-1:0]   qry_idx,
  output logic            qry_hit,
  output logic            qry_out,
  output logic [2:0]      qry_op
);
  localparam int CW = IW + 2;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  // split state for the second half of a scaled add
  logic          ph2;
  logic [IW-1:0] h_idx;
  logic [RW-1:0] h_dst, h_b;
  logic          h_hd;
  logic [CW-1:0] cnt, base, need;

  logic is_sc, fits, take, do2, wr_en;
  logic [IW-1:0] wr_idx;
  logic [RW-1:0] lb;
  logic a_live, b_live, a_live_m, b_live_m;
  logic [IW-1:0] a_idx, b_idx;

  logic [2:0]    op_n;
  logic [1:0]    ka_n, kb_n;
  logic [VW-1:0] va_n, vb_n;
  logic          pt_we, pt_cut;
  logic [RW-1:0] pt_reg;
  logic          c0_en;
  logic [IW-1:0] c0_idx;

  assign in_ready = !ph2;
  assign base     = trace_start ? '0 : cnt;
  assign is_sc    = (in_op == OP_SCADD);
  assign need     = is_sc ? CW'(2) : CW'(1);
  assign fits     = (base + need) <= DEPTH_C;
  assign take     = in_valid && !ph2 && fits;
  assign do2      = ph2 && !trace_start;
  assign wr_en    = take || do2;
  assign wr_idx   = do2 ? h_idx + IW'(1) : base[IW-1:0];
  assign lb       = ph2 ? h_b : in_src_b;
  assign a_live_m = a_live && !trace_start;
  assign b_live_m = b_live && !trace_start;

  always_comb begin
    if (ph2) begin
      op_n = OP_ADD;
      ka_n = K_NODE;
      va_n = VW'(h_idx);
    end else begin
      op_n = is_sc ? OP_SHL : in_op;
      ka_n = a_live_m ? K_NODE : K_EXT;
      va_n = a_live_m ? VW'(a_idx) : VW'(in_src_a);
    end
    if (!ph2 && (is_sc || in_b_imm)) begin
      kb_n = K_CONST;
      vb_n = VW'(in_imm);
    end else if (b_live_m) begin
      kb_n = K_NODE;
      vb_n = VW'(b_idx);
    end else begin
      kb_n = K_EXT;
      vb_n = VW'(lb);
    end
    c0_en  = wr_en && (ka_n == K_NODE);
    c0_idx = ph2 ? h_idx : a_idx;
    pt_we  = (take && !is_sc && in_has_dst) || (do2 && h_hd);
    pt_reg = ph2 ? h_dst : in_dst;
    pt_cut = !ph2 && (in_op == OP_LOAD);
  end

  dfg_prod_table #(.NREG(NREG), .RW(RW), .IW(IW)) u_prod (
    .clk(clk), .rst(rst), .clr_all(trace_start),
    .wr_en(pt_we), .wr_reg(pt_reg), .wr_idx(wr_idx), .wr_cut(pt_cut),
    .ra(in_src_a), .rb(lb),
    .a_live(a_live), .a_idx(a_idx), .b_live(b_live), .b_idx(b_idx)
  );

  dfg_flag_array #(.DEPTH(DEPTH), .IW(IW)) u_flags (
    .clk(clk), .rst(rst), .clr_all(trace_start),
    .set_en(wr_en), .set_idx(wr_idx),
    .c0_en(c0_en), .c0_idx(c0_idx),
    .c1_en(wr_en && (kb_n == K_NODE)), .c1_idx(b_idx),
    .rd_idx(qry_idx), .rd_flag(qry_out)
  );

  dfg_entry_ram #(.DEPTH(DEPTH), .IW(IW), .DW(3)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(op_n),
    .rd_idx(qry_idx), .rd_data(qry_op)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ph2       <= 1'b0;
      h_idx     <= '0;
      h_dst     <= '0;
      h_b       <= '0;
      h_hd      <= 1'b0;
      ent_valid <= 1'b0;
      ent_idx   <= '0;
      ent_op    <= '0;
      ent_kind_a <= '0;
      ent_val_a <= '0;
      ent_kind_b <= '0;
      ent_val_b <= '0;
      qry_hit   <= 1'b0;
    end else begin
      cnt       <= base + CW'(take) + CW'(do2);
      ph2       <= take && is_sc;
      if (take) begin
        h_idx <= base[IW-1:0];
        h_dst <= in_dst;
        h_b   <= in_src_b;
        h_hd  <= in_has_dst;
      end
      ent_valid <= wr_en;
      if (wr_en) begin
        ent_idx    <= wr_idx;
        ent_op     <= op_n;
        ent_kind_a <= ka_n;
        ent_val_a  <= va_n;
        ent_kind_b <= kb_n;
        ent_val_b  <= vb_n;
      end
      qry_hit <= CW'(qry_idx) < cnt;
    end
  end
endmodule

// File: rtl/dfg_tracker_chk.sv
module dfg_tracker_chk #(
  parameter int IW = 6,
  parameter int VW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          trace_start,
  input logic          in_ready,
  input logic          ent_valid,
  input logic [IW-1:0] ent_idx,
  input logic [2:0]    ent_op,
  input logic [1:0]    ent_kind_a,
  input logic [VW-1:0] ent_val_a,
  input logic [1:0]    ent_kind_b
);
  AST_START_SLOT0: assert property (@(posedge clk) disable iff (rst)
    ($past(trace_start) && ent_valid) |-> (ent_idx == '0 && ent_kind_a == 2'd0 && ent_kind_b != 2'd2)); // R1

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && $past(ent_valid) && !$past(trace_start)) |-> (ent_idx == $past(ent_idx) + IW'(1))); // R2

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ent_valid |-> (ent_kind_a != 2'd1 && ent_kind_a != 2'd3 && ent_kind_b != 2'd3)); // R5

  AST_NODE_OLDER: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && ent_kind_a == 2'd2) |-> (ent_val_a < VW'(ent_idx))); // R5

  AST_READY_GAP: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> in_ready); // R8

  AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (rst)
    (ent_valid && !in_ready && !trace_start) |=>
      (ent_valid && ent_op == 3'd0 && ent_kind_a == 2'd2 && ent_val_a == VW'($past(ent_idx)))); // R8
endmodule

bind dfg_tracker dfg_tracker_chk #(.IW(IW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .trace_start(trace_start), .in_ready(in_ready),
  .ent_valid(ent_valid), .ent_idx(ent_idx), .ent_op(ent_op),
  .ent_kind_a(ent_kind_a), .ent_val_a(ent_val_a), .ent_kind_b(ent_kind_b)
);

// File: tb/test_dfg_tracker.sv
module test_dfg_tracker;
  localparam int NREG = 32, DEPTH = 64, IMMW = 16;
  localparam int RW = 5, IW = 6, VW = 16;

  logic clk = 0, rst = 1, trace_start = 0, in_valid = 0;
  logic in_ready;
  logic [2:0] in_op = 0;
  logic [RW-1:0] in_dst = 0, in_src_a = 0, in_src_b = 0;
  logic in_has_dst = 0, in_b_imm = 0;
  logic [IMMW-1:0] in_imm = 0;
  logic ent_valid;
  logic [IW-1:0] ent_idx;
  logic [2:0] ent_op;
  logic [1:0] ent_kind_a, ent_kind_b;
  logic [VW-1:0] ent_val_a, ent_val_b;
  logic [IW-1:0] qry_idx = 0;
  logic qry_hit, qry_out;
  logic [2:0] qry_op;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dfg_tracker #(.NREG(NREG), .DEPTH(DEPTH), .IMMW(IMMW)) i_dfg_tracker (
    .clk(clk), .rst(rst), .trace_start(trace_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_op(in_op), .in_dst(in_dst), .in_has_dst(in_has_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_b_imm(in_b_imm), .in_imm(in_imm),
    .ent_valid(ent_valid), .ent_idx(ent_idx), .ent_op(ent_op),
    .ent_kind_a(ent_kind_a), .ent_val_a(ent_val_a),
    .ent_kind_b(ent_kind_b), .ent_val_b(ent_val_b),
    .qry_idx(qry_idx), .qry_hit(qry_hit), .qry_out(qry_out), .qry_op(qry_op)
  );

  // bench model of the graph state
  bit m_pv [NREG];
  int m_pi [NREG];
  bit m_cut [NREG];
  bit m_fl [DEPTH];
  int m_op [DEPTH];
  int m_cnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_clear();
    for (int i = 0; i < NREG; i++) begin m_pv[i] = 0; m_cut[i] = 0; end
    for (int i = 0; i < DEPTH; i++) m_fl[i] = 0;
    m_cnt = 0;
  endfunction

  function automatic void cls(input int r, output int k, output int v);
    if (m_pv[r] && !m_cut[r]) begin
      k = 2; v = m_pi[r]; m_fl[m_pi[r]] = 0;
    end else begin
      k = 0; v = r;
    end
  endfunction

  task automatic chk_ent(input string tag, input int idx, input int op,
                         input int ka, input int va, input int kb, input int vb);
    chk(ent_valid == 1, {tag, " valid"}, ent_valid, 1);
    chk(ent_idx == idx, {tag, " idx R2"}, ent_idx, idx);
    chk(ent_op == op, {tag, " op"}, ent_op, op);
    chk(ent_kind_a == ka && ent_val_a == va, {tag, " opA R5"}, {ent_kind_a, ent_val_a}, {ka[1:0], va[15:0]});
    chk(ent_kind_b == kb && ent_val_b == vb, {tag, " opB R5"}, {ent_kind_b, ent_val_b}, {kb[1:0], vb[15:0]});
  endtask

  task automatic send(input string tag, input int op, input int dst, input bit hd,
                      input int a, input int b, input bit bi, input int imm, input bit st);
    int need, ka, va, kb, vb;
    if (st) m_clear();
    need = (op == 7) ? 2 : 1;
    trace_start = st; in_valid = 1; in_op = op[2:0]; in_dst = dst[RW-1:0];
    in_has_dst = hd; in_src_a = a[RW-1:0]; in_src_b = b[RW-1:0];
    in_b_imm = bi; in_imm = imm[IMMW-1:0];
    @(negedge clk);
    in_valid = 0; trace_start = 0;
    if (m_cnt + need > DEPTH) begin
      chk(ent_valid == 0, {tag, " R9 dropped"}, ent_valid, 0);
      return;
    end
    cls(a, ka, va);
    if (op == 7 || bi) begin kb = 1; vb = imm & 16'hffff; end
    else cls(b, kb, vb);
    chk_ent(tag, m_cnt, (op == 7) ? 5 : op, ka, va, kb, vb);
    m_fl[m_cnt] = 1;
    m_op[m_cnt] = (op == 7) ? 5 : op;
    if (op != 7 && hd) begin
      m_pv[dst] = 1; m_pi[dst] = m_cnt; m_cut[dst] = (op == 6);
    end
    m_cnt++;
    if (op == 7) begin
      chk(in_ready == 0, {tag, " R8 ready low"}, in_ready, 0);
      @(negedge clk);
      m_fl[m_cnt-1] = 0;
      cls(b, kb, vb);
      chk_ent({tag, " R8 add"}, m_cnt, 0, 2, m_cnt - 1, kb, vb);
      chk(in_ready == 1, {tag, " R8 ready back"}, in_ready, 1);
      m_fl[m_cnt] = 1; m_op[m_cnt] = 0;
      if (hd) begin m_pv[dst] = 1; m_pi[dst] = m_cnt; m_cut[dst] = 0; end
      m_cnt++;
    end
  endtask

  task automatic qcheck(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      qry_idx = i[IW-1:0];
      @(negedge clk);
      chk(qry_hit == (i < m_cnt), {tag, " hit R1"}, qry_hit, i < m_cnt);
      chk(qry_out == ((i < m_cnt) && m_fl[i]), {tag, " flag R3 R4"}, qry_out, (i < m_cnt) && m_fl[i]);
      if (i < m_cnt) chk(qry_op == m_op[i], {tag, " op R3"}, qry_op, m_op[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_clear();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(ent_valid == 0, "R1 reset ent_valid", ent_valid, 0);
    chk(in_ready == 1, "R1 reset in_ready", in_ready, 1);
    qcheck("R1 after reset");
    // R1 + R5: start together with the first instruction
    send("R1 start insert", 0, 3, 1, 9, 10, 0, 0, 1);
    // R5: self read sees previous producer; R4 clears slot 0
    send("R5 self read", 1, 3, 1, 3, 0, 1, 1, 0);
    // R11: both operands from one producer
    send("R11 same src", 4, 4, 1, 3, 3, 0, 0, 0);
    // R6: rewrite then read newest
    send("R6 rewrite", 2, 4, 1, 9, 4, 0, 0, 0);
    send("R6 read newest", 3, 11, 1, 4, 12, 0, 0, 0);
    // R7: load as cut
    send("R7 load", 6, 5, 1, 4, 0, 1, 8, 0);
    send("R7 use load", 0, 6, 1, 5, 5, 0, 0, 0);
    // R10: no destination
    send("R10 store", 3, 6, 0, 11, 3, 0, 0, 0);
    send("R10 reader", 0, 12, 1, 6, 6, 0, 0, 0);
    // R8: scaled add
    send("R8 scadd", 7, 8, 1, 6, 12, 0, 2, 0);
    send("R8 after", 1, 13, 1, 8, 8, 0, 0, 0);
    qcheck("R3 R4 R7 directed");
    // R1: start without instruction empties table
    trace_start = 1; m_clear();
    @(negedge clk);
    trace_start = 0;
    qcheck("R1 start only");
    // R9: fill, scaled add that does not fit, then single that does
    send("R9 fill", 0, 7, 1, 1, 2, 0, 0, 1);
    for (int i = 1; i < DEPTH - 1; i++) send("R9 fill", 0, 20, 1, 20, 21, 0, 0, 0);
    send("R9 split no room", 7, 7, 1, 1, 1, 0, 3, 0);
    send("R9 last slot", 0, 22, 1, 7, 7, 0, 0, 0);
    send("R9 full", 0, 23, 1, 7, 7, 0, 0, 0);
    qcheck("R9 full table");
    // random mix
    for (int n = 0; n < 400; n++) begin
      send("R5 random", $urandom % 8, $urandom % 8, ($urandom % 10) != 0,
           $urandom % 8, $urandom % 8, ($urandom % 4) == 0, $urandom % 65536,
           ($urandom % 40) == 0);
      if (n % 40 == 39) qcheck("R4 random");
    end
    qcheck("R4 random end");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule